// File: doc/BRIEF.md
# Packet-to-TDM Playout Buffer Controller

This block sits between a packet receive path and a constant-rate TDM transmit path for a single connection. Payload bytes arrive in bursts, one per cycle on a valid/ready port, and go into a circular store. A strobe paced by the TDM byte clock takes bytes out again, one per strobe. Playout does not begin until the buffered amount reaches a configured delay threshold, so every byte leaves later by roughly that amount. This absorbs variation in packet arrival time.

The controller tracks the fill level in bytes. It reports overrun when the level reaches the configured ceiling and underrun when a strobe finds the buffer empty. During underrun it sends a configured conditioning byte to the TDM side and returns to filling. Overrun refuses new bytes and counts them as dropped. A status set reports the level, the state, a filling flag, and low and high watermarks that software can clear. These let software judge the headroom at both ends of the buffer. A combinational flag marks configurations that leave too little room between the threshold and the ceiling.

Top module: `jbuf_playout_ctrl`

## Requirements
- R1: While reset is asserted, the status reads level 0, state 2'b00 (ok), filling 1, low and high watermarks 0, drop count 0, and `wr_ready` is 1.
- R2: A byte is stored when `wr_valid` and `wr_ready` are both high at a clock edge, and the level then rises by one. A store and a playout read at the same edge leave the level unchanged.
- R3: While filling is 1, a strobe consumes nothing and returns the conditioning byte. Filling clears at the first edge at which the registered level is at least the threshold.
- R4: Stored bytes leave in the order they were written. `rd_data` is registered and reflects a strobe from the edge that sampled it.
- R5: A strobe while playing with level 0 sets state 2'b01 (underrun) and filling 1, and returns the conditioning byte. State returns to 2'b00 when the threshold is next reached.
- R6: When the level after an edge is at or above the effective ceiling, state is 2'b10 (overrun). In that state `wr_ready` is 0, and each cycle with `wr_valid` high adds one to the drop count.
- R7: Overrun ends, giving state 2'b00, at the first edge after which the level plus the packet size is below the effective ceiling.
- R8: The low and high watermarks hold the extremes of the level since reset or since the last clear pulse. A clear pulse reloads both with the level that follows that edge.
- R9: `cfg_error` is 1 exactly when the threshold is not below the configured maximum, or when the maximum minus the threshold is not above the packet size.
- R10: The effective ceiling is the configured maximum, limited to the storage depth DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Payload byte offered |
| wr_data | input | 8 | Payload byte |
| wr_ready | output | 1 | Byte will be accepted |
| rd_strobe | input | 1 | TDM byte-rate playout request |
| rd_data | output | 8 | Registered playout byte |
| cfg_threshold | input | LW | Playout start threshold in bytes |
| cfg_max | input | LW | Overrun ceiling in bytes |
| cfg_pkt | input | LW | Packet payload size in bytes |
| cfg_cond_byte | input | 8 | Conditioning byte |
| wm_clear | input | 1 | Reload both watermarks |
| stat_level | output | LW | Current fill level |
| stat_state | output | 2 | 00 ok, 01 underrun, 10 overrun |
| stat_filling | output | 1 | Waiting for threshold |
| stat_min | output | LW | Low watermark |
| stat_max | output | LW | High watermark |
| stat_drops | output | DROP_W | Bytes refused during overrun |
| cfg_error | output | 1 | Configuration rule broken |

## Verification
The assertions assume that the configuration inputs change only while reset is held. They also assume that DEPTH is a power of two, so that the pointers wrap with the level. The bench changes the threshold, ceiling and packet size only during reset, and it sweeps the configuration-error rule over a grid of values during that reset. Between resets it drives bursts of packet-sized writes at several densities against a strobe every fourth cycle. The densities are chosen so that underrun, overrun and watermark clears all occur with the configuration held fixed.

// File: rtl/jbuf_pkg.sv
package jbuf_pkg;
  localparam int JB_CW = 13;
  typedef logic [JB_CW-1:0] jb_cnt_t;

  typedef enum logic [1:0] {
    JB_OK    = 2'b00,
    JB_UNDER = 2'b01,
    JB_OVER  = 2'b10
  } jb_state_e;

  // level after one edge given a store and a playout read
  function automatic jb_cnt_t jb_level_step(jb_cnt_t lvl, logic push, logic pop);
    jb_cnt_t r;
    r = lvl;
    if (push && !pop) r = lvl + jb_cnt_t'(1);
    else if (pop && !push) r = lvl - jb_cnt_t'(1);
    return r;
  endfunction

  // ceiling limited to physical storage
  function automatic jb_cnt_t jb_clamp(jb_cnt_t mx, jb_cnt_t depth);
    return (mx > depth) ? depth : mx;
  endfunction

  // threshold/ceiling/packet consistency rule
  function automatic logic jb_cfg_bad(jb_cnt_t thr, jb_cnt_t mx, jb_cnt_t pkt);
    if (thr >= mx) return 1'b1;
    return ((mx - thr) <= pkt);
  endfunction

  // overrun release: one packet of room below the ceiling
  function automatic logic jb_ovr_release(jb_cnt_t lvl, jb_cnt_t mx, jb_cnt_t pkt);
    logic [JB_CW:0] s;
    s = {1'b0, lvl} + {1'b0, pkt};
    return (s < {1'b0, mx});
  endfunction
endpackage

// File: rtl/jb_store.sv
module jb_store #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] push_data,
  input  logic       pop,
  input  logic       rd_strobe,
  input  logic [7:0] cond_byte,
  output logic [7:0] rd_data
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [7:0]    head_byte;
  logic          armed_q;

  assign head_byte = mem[rptr_q];

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      rd_data <= 8'h00;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (push) wptr_q <= wptr_q + AW'(1);
      if (pop)  rptr_q <= rptr_q + AW'(1);
      if (rd_strobe) rd_data <= pop ? head_byte : cond_byte;
    end
  end

  // R5
  cond_out_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (rd_strobe && !pop) |=> (rd_data == $past(cond_byte)));

  // R4
  pop_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> rd_strobe);
endmodule

// File: rtl/jb_level_ctrl.sv
module jb_level_ctrl
  import jbuf_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LW     = $clog2(DEPTH + 1),
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              rd_strobe,
  input  logic [LW-1:0]     cfg_threshold,
  input  logic [LW-1:0]     cfg_max,
  input  logic [LW-1:0]     cfg_pkt,
  output logic              wr_ready,
  output logic              push,
  output logic              pop,
  output logic [LW-1:0]     level,
  output logic [LW-1:0]     level_nx,
  output jb_state_e         state,
  output logic              filling,
  output logic [DROP_W-1:0] drops
);
  localparam jb_cnt_t DEPTH_C = jb_cnt_t'(DEPTH);

  logic [LW-1:0]     level_q;
  jb_state_e         state_q, state_d;
  logic              filling_q, filling_d;
  logic [DROP_W-1:0] drops_q;
  logic              armed_q;

  jb_cnt_t lvl_w, thr_w, pkt_w, emax_w, lvl_nx_w;
  logic    drop_evt, und_evt, thr_met, ovr_enter, ovr_release;

  assign lvl_w  = jb_cnt_t'(level_q);
  assign thr_w  = jb_cnt_t'(cfg_threshold);
  assign pkt_w  = jb_cnt_t'(cfg_pkt);
  assign emax_w = jb_clamp(jb_cnt_t'(cfg_max), DEPTH_C);

  assign wr_ready    = (state_q != JB_OVER);
  assign push        = wr_valid && wr_ready;
  assign drop_evt    = wr_valid && !wr_ready;
  assign pop         = rd_strobe && !filling_q && (level_q != '0);
  assign und_evt     = rd_strobe && !filling_q && (level_q == '0);
  assign thr_met     = filling_q && (lvl_w >= thr_w);
  assign lvl_nx_w    = jb_level_step(lvl_w, push, pop);
  assign ovr_enter   = (lvl_nx_w >= emax_w);
  assign ovr_release = jb_ovr_release(lvl_nx_w, emax_w, pkt_w);

  always_comb begin
    state_d   = state_q;
    filling_d = filling_q;
    if (und_evt) begin
      state_d   = JB_UNDER;
      filling_d = 1'b1;
    end else if (thr_met) begin
      filling_d = 1'b0;
      if (state_q != JB_OVER) state_d = JB_OK;
    end
    if (state_q == JB_OVER && ovr_release) state_d = JB_OK;
    if (ovr_enter) state_d = JB_OVER;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q   <= '0;
      state_q   <= JB_OK;
      filling_q <= 1'b1;
      drops_q   <= '0;
      armed_q   <= 1'b0;
    end else begin
      armed_q   <= 1'b1;
      level_q   <= LW'(lvl_nx_w);
      state_q   <= state_d;
      filling_q <= filling_d;
      if (drop_evt) drops_q <= drops_q + DROP_W'(1);
    end
  end

  assign level    = level_q;
  assign level_nx = LW'(lvl_nx_w);
  assign state    = state_q;
  assign filling  = filling_q;
  assign drops    = drops_q;

  // R2
  level_track_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    1'b1 |=> (jb_cnt_t'(level_q) ==
              $past(lvl_w) + jb_cnt_t'($past(push)) - jb_cnt_t'($past(pop))));

  // R3
  hold_while_filling_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (filling_q && rd_strobe) |=> (jb_cnt_t'(level_q) == $past(lvl_w) + jb_cnt_t'($past(push))));

  // R5
  underrun_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (rd_strobe && !filling_q && level_q == '0) |=> (state_q == JB_UNDER && filling_q));

  // R6
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (jb_cnt_t'(level_q) >= emax_w) |-> (state_q == JB_OVER && !wr_ready));

  // R6
  drop_count_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (wr_valid && state_q == JB_OVER) |=> (drops_q == $past(drops_q) + DROP_W'(1)));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    ($past(state_q) == JB_OVER && state_q != JB_OVER)
      |-> jb_ovr_release(jb_cnt_t'(level_q), emax_w, pkt_w));

  // R10
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jb_cnt_t'(level_q) <= DEPTH_C);
endmodule

// File: rtl/jb_watermark.sv
module jb_watermark #(
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [LW-1:0] level_nx,
  output logic [LW-1:0] low,
  output logic [LW-1:0] high
);
  logic [LW-1:0] low_q, high_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q  <= '0;
      high_q <= '0;
    end else if (clear) begin
      low_q  <= level_nx;
      high_q <= level_nx;
    end else begin
      if (level_nx < low_q)  low_q  <= level_nx;
      if (level_nx > high_q) high_q <= level_nx;
    end
  end

  assign low  = low_q;
  assign high = high_q;

  // R8
  wm_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_q <= high_q);
endmodule

// File: rtl/jbuf_playout_ctrl.sv
module jbuf_playout_ctrl
  import jbuf_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DROP_W = 16,
  localparam int LW    = $clog2(DEPTH + 1),
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  output logic              wr_ready,
  input  logic              rd_strobe,
  output logic [7:0]        rd_data,
  input  logic [LW-1:0]     cfg_threshold,
  input  logic [LW-1:0]     cfg_max,
  input  logic [LW-1:0]     cfg_pkt,
  input  logic [7:0]        cfg_cond_byte,
  input  logic              wm_clear,
  output logic [LW-1:0]     stat_level,
  output logic [1:0]        stat_state,
  output logic              stat_filling,
  output logic [LW-1:0]     stat_min,
  output logic [LW-1:0]     stat_max,
  output logic [DROP_W-1:0] stat_drops,
  output logic              cfg_error
);
  logic          push_w, pop_w;
  logic [LW-1:0] level_w, level_nx_w;
  jb_state_e     state_w;

  jb_level_ctrl #(.DEPTH(DEPTH), .LW(LW), .DROP_W(DROP_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_valid      (wr_valid),
    .rd_strobe     (rd_strobe),
    .cfg_threshold (cfg_threshold),
    .cfg_max       (cfg_max),
    .cfg_pkt       (cfg_pkt),
    .wr_ready      (wr_ready),
    .push          (push_w),
    .pop           (pop_w),
    .level         (level_w),
    .level_nx      (level_nx_w),
    .state         (state_w),
    .filling       (stat_filling),
    .drops         (stat_drops)
  );

  jb_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_w),
    .push_data (wr_data),
    .pop       (pop_w),
    .rd_strobe (rd_strobe),
    .cond_byte (cfg_cond_byte),
    .rd_data   (rd_data)
  );

  jb_watermark #(.LW(LW)) u_wm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (wm_clear),
    .level_nx (level_nx_w),
    .low      (stat_min),
    .high     (stat_max)
  );

  assign stat_level = level_w;
  assign stat_state = state_w;
  assign cfg_error  = jb_cfg_bad(jb_cnt_t'(cfg_threshold), jb_cnt_t'(cfg_max),
                                 jb_cnt_t'(cfg_pkt));

  // R8
  wm_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_min <= stat_level) && (stat_level <= stat_max));

  // R1
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat_state));
endmodule

// File: tb/test_jbuf_playout_ctrl.sv
module test_jbuf_playout_ctrl;
  localparam int DEPTH = 16;
  localparam int DW    = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_strobe = 1'b0, wm_clear = 1'b0;
  logic [7:0] wr_data = 8'h00, cond = 8'hA5;
  logic [LW-1:0] cfg_thr = '0, cfg_mx = '0, cfg_pk = '0;
  logic wr_ready, filling, cfg_error;
  logic [7:0] rd_data;
  logic [LW-1:0] lvl, wmin, wmax;
  logic [1:0] st;
  logic [DW-1:0] drops;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  jbuf_playout_ctrl #(.DEPTH(DEPTH), .DROP_W(DW)) i_jbuf_playout_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .cfg_threshold(cfg_thr), .cfg_max(cfg_mx), .cfg_pkt(cfg_pk),
    .cfg_cond_byte(cond), .wm_clear(wm_clear), .stat_level(lvl),
    .stat_state(st), .stat_filling(filling), .stat_min(wmin),
    .stat_max(wmax), .stat_drops(drops), .cfg_error(cfg_error)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // bench model state
  int mlvl, mst, mfill, mmin, mmax, mdrop, exp_rd;
  bit chk_rd;
  logic [7:0] mq[$];

  task automatic compare(input string lvl_req);
    check(int'(lvl) == mlvl, lvl_req, int'(lvl), mlvl);
    check(int'(st) == mst, "R5 R6 R7 state", int'(st), mst);
    check(int'(filling) == mfill, "R3 filling", int'(filling), mfill);
    check(int'(wr_ready) == int'(mst != 2), "R6 ready", int'(wr_ready), int'(mst != 2));
    check(int'(drops) == mdrop, "R6 drops", int'(drops), mdrop);
    check(int'(wmin) == mmin, "R8 min", int'(wmin), mmin);
    check(int'(wmax) == mmax, "R8 max", int'(wmax), mmax);
    if (chk_rd) check(int'(rd_data) == exp_rd, "R4 data", int'(rd_data), exp_rd);
  endtask

  task automatic run_cfg(input int thr, input int mx, input int pk, input int wpct, input int ncyc);
    int emax, bleft, dcnt, nl;
    bit push, pop, und, thrm;
    string lreq;
    emax = (mx > DEPTH) ? DEPTH : mx;
    lreq = (mx > DEPTH) ? "R10 level" : "R2 level";
    @(negedge clk);
    rst_n = 1'b0; wr_valid = 1'b0; rd_strobe = 1'b0; wm_clear = 1'b0;
    cfg_thr = LW'(thr); cfg_mx = LW'(mx); cfg_pk = LW'(pk);
    repeat (3) @(negedge clk);
    mlvl = 0; mst = 0; mfill = 1; mmin = 0; mmax = 0; mdrop = 0; chk_rd = 0;
    mq.delete();
    compare("R1 level");
    rst_n = 1'b1;
    bleft = 0; dcnt = 0;
    for (int c = 0; c < ncyc; c++) begin
      if (bleft == 0 && $urandom_range(99) < wpct) bleft = pk;
      wr_valid  = (bleft > 0);
      wr_data   = 8'(dcnt);
      rd_strobe = ((c % 4) == 3);
      wm_clear  = ($urandom_range(199) == 0);
      push = wr_valid && (mst != 2);
      pop  = rd_strobe && !mfill && (mlvl > 0);
      und  = rd_strobe && !mfill && (mlvl == 0);
      thrm = mfill && (mlvl >= thr);
      chk_rd = rd_strobe;
      if (rd_strobe) exp_rd = pop ? int'(mq.pop_front()) : int'(cond);
      if (push) mq.push_back(wr_data);
      if (wr_valid && mst == 2) mdrop++;
      if (wr_valid) begin bleft--; dcnt++; end
      nl = mlvl + int'(push) - int'(pop);
      if (und) begin mst = 1; mfill = 1; end
      else if (thrm) begin mfill = 0; if (mst != 2) mst = 0; end
      if (mst == 2 && (nl + pk) < emax) mst = 0;
      if (nl >= emax) mst = 2;
      mlvl = nl;
      if (wm_clear) begin mmin = nl; mmax = nl; end
      else begin
        if (nl < mmin) mmin = nl;
        if (nl > mmax) mmax = nl;
      end
      @(negedge clk);
      compare(lreq);
    end
    wr_valid = 1'b0; rd_strobe = 1'b0; wm_clear = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R9 grid sweep while reset is held
    for (int t = 0; t < 8; t++)
      for (int m = 0; m < 8; m++)
        for (int p = 0; p < 4; p++) begin
          cfg_thr = LW'(t); cfg_mx = LW'(m); cfg_pk = LW'(p);
          #1;
          check(int'(cfg_error) == int'((t >= m) || ((m - t) <= p)), "R9 cfg_error",
                int'(cfg_error), int'((t >= m) || ((m - t) <= p)));
        end
    for (int d = 0; d < 3; d++) begin
      int pct;
      pct = (d == 0) ? 15 : (d == 1) ? 40 : 90;
      run_cfg(4, 12, 3, pct, 2000);
      run_cfg(2, 8, 2, pct, 2000);
      run_cfg(6, 16, 4, pct, 2000);
      run_cfg(5, 20, 3, pct, 2000);  // R10 ceiling above depth
      run_cfg(3, 16, 1, pct, 2000);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule